// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the datapath of a small processor in which every transfer between storage elements goes over one shared internal bus. It holds a set of general registers, a temporary operand register and a result register. Each register has two gates: an output gate that places its contents on the bus, and an input gate that loads the bus value on the next rising clock edge. An external data source (for example, memory read data) can also drive the bus through its own gate.

A sequencer outside the block supplies a fresh control word every cycle. The control word holds the output gates, the input gates and an ALU function code. The ALU is purely combinational. Its first operand always comes from the temporary register and its second operand comes straight from the bus. Only the result register can capture the ALU output. A binary operation therefore takes three bus cycles: stage the first operand, compute into the result register, then move the result to its destination.

The block watches the output gates and raises an error flag when a control word opens more than one of them. Such a word is then kept from changing any stored state.

Top module: `sbus_datapath`

## Requirements
- R1: After the active-low asynchronous reset, every general register, the temporary register and the result register hold zero.
- R2: When exactly one output gate is open, bus_o equals that source's value in the same cycle. The source bit positions in the driver set are general register k at position k, then the temporary register, then the result register, then the external source.
- R3: When no output gate is open, bus_o reads zero.
- R4: When two or more output gates are open, bus_err_o is 1 in that same cycle and bus_o is the bitwise OR of all open sources. Otherwise bus_err_o is 0.
- R5: In a cycle with bus_err_o at 1, no register changes value, whatever input gates are set.
- R6: In a cycle without error, every register whose input gate is set loads bus_o at the rising edge. Several input gates may load the same value together, and registers with a clear input gate keep their value.
- R7: The result register loads the ALU output only when its input gate is set. The ALU output is computed from A = temporary register (pre-edge value) and B = bus_o.
- R8: ALU function codes: 3'b000 gives A+B modulo 2^DATA_W; 3'b001 gives A−B modulo 2^DATA_W; 3'b010 gives A AND B; 3'b011 gives A OR B; 3'b100 gives A XOR B; 3'b101 to 3'b111 give zero.
- R9: A register that is read and loaded in the same cycle drives its pre-edge value. This covers a general register gated out and back in, and the result register gated out as operand B while it captures. When the temporary and result input gates are set together, the result uses the old temporary value.
- R10: The three-step sequence (R1 out with temp in; R2 out with add and result in; result out with R3 in) leaves R1+R2 in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gpr_out_i | input | NUM_GPR | Output gates of the general registers |
| gpr_in_i | input | NUM_GPR | Input gates of the general registers |
| tmp_out_i | input | 1 | Output gate of the temporary (operand A) register |
| tmp_in_i | input | 1 | Input gate of the temporary register |
| res_out_i | input | 1 | Output gate of the result register |
| res_in_i | input | 1 | Input gate of the result register (captures ALU output) |
| ext_out_i | input | 1 | Gate placing ext_data_i on the bus |
| ext_data_i | input | DATA_W | External data source |
| alu_fn_i | input | 3 | ALU function code |
| bus_o | output | DATA_W | Current bus value |
| bus_err_o | output | 1 | More than one output gate is open this cycle |

## Verification
Two functions can fall in the same cycle here. The first pair is a register's output gate and its own input gate: a general register is gated out and back in, or the result register supplies operand B while it captures a new result. The second pair is the temporary and result input gates set together. The bench builds these words on purpose and also mixes them into a long stream of random legal and illegal control words. A behavioural model applies the rule that every read sees pre-edge contents and every load commits at the edge. The model is compared with bus_o and bus_err_o in every cycle, and stored values are read back later through the output gates.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_XOR = 3'd4
  } alu_fn_e;

  // temp, result and external source follow the general registers
  localparam int unsigned NUM_FIXED_SRC = 3;
endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_SRC = 7
) (
  input  logic [NUM_SRC-1:0][DATA_W-1:0] src_i,
  input  logic [NUM_SRC-1:0]             oe_i,
  output logic [DATA_W-1:0]              bus_o,
  output logic                           multi_o
);
  localparam int unsigned CNT_W = $clog2(NUM_SRC + 1);

  logic [CNT_W-1:0] n_drv;

  always_comb begin
    bus_o = '0;
    n_drv = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (oe_i[i]) bus_o = bus_o | src_i[i];
      n_drv = n_drv + CNT_W'(oe_i[i]);
    end
  end

  assign multi_o = (n_drv > CNT_W'(1));
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        fn_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      FN_ADD:  res_o = a_i + b_i;
      FN_SUB:  res_o = a_i - b_i;
      FN_AND:  res_o = a_i & b_i;
      FN_OR:   res_o = a_i | b_i;
      FN_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_GPR = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GPR-1:0] gpr_out_i,
  input  logic [NUM_GPR-1:0] gpr_in_i,
  input  logic               tmp_out_i,
  input  logic               tmp_in_i,
  input  logic               res_out_i,
  input  logic               res_in_i,
  input  logic               ext_out_i,
  input  logic [DATA_W-1:0]  ext_data_i,
  input  logic [2:0]         alu_fn_i,
  output logic [DATA_W-1:0]  bus_o,
  output logic               bus_err_o
);
  localparam int unsigned NUM_SRC = NUM_GPR + NUM_FIXED_SRC;
  localparam int unsigned TMP_IDX = NUM_GPR;
  localparam int unsigned RES_IDX = NUM_GPR + 1;
  localparam int unsigned EXT_IDX = NUM_GPR + 2;

  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q;
  logic [DATA_W-1:0]              tmp_q, res_q, alu_res;
  logic [NUM_SRC-1:0][DATA_W-1:0] src;
  logic [NUM_SRC-1:0]             oe;
  logic                           ld_ok;

  assign oe = {ext_out_i, res_out_i, tmp_out_i, gpr_out_i};

  always_comb begin
    for (int k = 0; k < NUM_GPR; k++) src[k] = gpr_q[k];
    src[TMP_IDX] = tmp_q;
    src[RES_IDX] = res_q;
    src[EXT_IDX] = ext_data_i;
  end

  sbus_bus_mux #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) i_mux (
    .src_i  (src),
    .oe_i   (oe),
    .bus_o  (bus_o),
    .multi_o(bus_err_o)
  );

  // an illegal word must not commit anything
  assign ld_ok = !bus_err_o;

  for (genvar k = 0; k < NUM_GPR; k++) begin : g_gpr
    sbus_reg #(.DATA_W(DATA_W)) i_gpr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (gpr_in_i[k] && ld_ok),
      .d_i   (bus_o),
      .q_o   (gpr_q[k])
    );
  end

  sbus_reg #(.DATA_W(DATA_W)) i_tmp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (tmp_in_i && ld_ok),
    .d_i   (bus_o),
    .q_o   (tmp_q)
  );

  sbus_alu #(.DATA_W(DATA_W)) i_alu (
    .a_i  (tmp_q),
    .b_i  (bus_o),
    .fn_i (alu_fn_i),
    .res_o(alu_res)
  );

  sbus_reg #(.DATA_W(DATA_W)) i_res (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (res_in_i && ld_ok),
    .d_i   (alu_res),
    .q_o   (res_q)
  );
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_GPR = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_GPR-1:0]             gpr_out_i,
  input logic [NUM_GPR-1:0]             gpr_in_i,
  input logic                           tmp_out_i,
  input logic                           tmp_in_i,
  input logic                           res_out_i,
  input logic                           res_in_i,
  input logic                           ext_out_i,
  input logic [DATA_W-1:0]              bus_o,
  input logic                           bus_err_o,
  input logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q,
  input logic [DATA_W-1:0]              tmp_q,
  input logic [DATA_W-1:0]              res_q
);
  logic [NUM_GPR+2:0] drv;
  assign drv = {ext_out_i, res_out_i, tmp_out_i, gpr_out_i};

  assert_idle_bus_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv == '0) |-> (bus_o == '0));

  assert_multi_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o == ($countones(drv) > 1));

  assert_err_freezes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |=> (gpr_q == $past(gpr_q)) && (tmp_q == $past(tmp_q)) && (res_q == $past(res_q)));

  assert_tmp_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmp_in_i && !bus_err_o) |=> (tmp_q == $past(bus_o)));

  assert_res_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_in_i |=> $stable(res_q));

  assert_res_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drv) && res_out_i |-> (bus_o == res_q));

  for (genvar k = 0; k < NUM_GPR; k++) begin : g_chk
    assert_gpr_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(drv) && gpr_out_i[k] |-> (bus_o == gpr_q[k]));
    assert_gpr_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gpr_in_i[k] && !bus_err_o) |=> (gpr_q[k] == $past(bus_o)));
    assert_gpr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gpr_in_i[k] |=> $stable(gpr_q[k]));
  end
endmodule

bind sbus_datapath sbus_datapath_chk #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gpr_out_i(gpr_out_i),
  .gpr_in_i (gpr_in_i),
  .tmp_out_i(tmp_out_i),
  .tmp_in_i (tmp_in_i),
  .res_out_i(res_out_i),
  .res_in_i (res_in_i),
  .ext_out_i(ext_out_i),
  .bus_o    (bus_o),
  .bus_err_o(bus_err_o),
  .gpr_q    (gpr_q),
  .tmp_q    (tmp_q),
  .res_q    (res_q)
);

// File: tb/test_sbus_datapath.sv
`timescale 1ns/1ps
module test_sbus_datapath;
  localparam int W = 16;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] gpr_out = '0, gpr_in = '0;
  logic         tmp_out = 1'b0, tmp_in = 1'b0, res_out = 1'b0, res_in = 1'b0, ext_out = 1'b0;
  logic [W-1:0] ext_data = '0;
  logic [2:0]   fn = '0;
  logic [W-1:0] bus;
  logic         err;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_gpr [N];
  logic [W-1:0] m_tmp, m_res;

  always #10 clk = ~clk;

  sbus_datapath #(.DATA_W(W), .NUM_GPR(N)) i_sbus_datapath (
    .clk_i(clk), .rst_ni(rst_n),
    .gpr_out_i(gpr_out), .gpr_in_i(gpr_in),
    .tmp_out_i(tmp_out), .tmp_in_i(tmp_in),
    .res_out_i(res_out), .res_in_i(res_in),
    .ext_out_i(ext_out), .ext_data_i(ext_data),
    .alu_fn_i(fn), .bus_o(bus), .bus_err_o(err)
  );

  function automatic logic [W-1:0] ref_alu(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [2:0] f);
    case (f)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one control word: drive at negedge, compare, then advance the model past the edge
  task automatic step(input logic [N-1:0] go, input logic [N-1:0] gi,
                      input logic to, input logic ti, input logic ro, input logic ri,
                      input logic eo, input logic [W-1:0] ed, input logic [2:0] f,
                      input string tag);
    logic [W-1:0] eb;
    int nd;
    @(negedge clk);
    gpr_out = go; gpr_in = gi; tmp_out = to; tmp_in = ti;
    res_out = ro; res_in = ri; ext_out = eo; ext_data = ed; fn = f;
    #2;
    eb = '0; nd = 0;
    for (int k = 0; k < N; k++) if (go[k]) begin eb |= m_gpr[k]; nd++; end
    if (to) begin eb |= m_tmp; nd++; end
    if (ro) begin eb |= m_res; nd++; end
    if (eo) begin eb |= ed; nd++; end
    check({tag, " bus"}, bus, eb);
    check({tag, " err"}, W'(err), W'(nd > 1));
    if (nd <= 1) begin
      if (ri) m_res = ref_alu(m_tmp, eb, f);
      if (ti) m_tmp = eb;
      for (int k = 0; k < N; k++) if (gi[k]) m_gpr[k] = eb;
    end
  endtask

  task automatic load(input int k, input logic [W-1:0] v, input string tag);
    step(N'(1) << k, '0, 0, 0, 0, 0, 1, v, 3'd0, tag);
    step('0, N'(1) << k, 0, 0, 0, 0, 1, v, 3'd0, tag);
  endtask

  task automatic peek_gpr(input int k, input string tag);
    step(N'(1) << k, '0, 0, 0, 0, 0, 0, '0, 3'd0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) m_gpr[k] = '0;
    m_tmp = '0; m_res = '0;
    #55 rst_n = 1'b1;

    // R1: everything zero after reset
    for (int k = 0; k < N; k++) peek_gpr(k, "R1 gpr");
    step('0, '0, 1, 0, 0, 0, 0, '0, 3'd0, "R1 tmp");
    step('0, '0, 0, 0, 1, 0, 0, '0, 3'd0, "R1 res");

    // R3: idle bus with junk on the external data
    step('0, '0, 0, 0, 0, 0, 0, 16'hFFFF, 3'd0, "R3 idle");

    // R6/R2: load from external source and read back
    load(0, 16'h1234, "R6 ld0"); load(1, 16'h0F0F, "R6 ld1");
    load(2, 16'h8001, "R6 ld2"); load(3, 16'h00FF, "R6 ld3");
    for (int k = 0; k < N; k++) peek_gpr(k, "R2 gpr");

    // R6: copy R0 into R2 and R3 together (broadcast)
    step(4'b0001, 4'b1100, 0, 0, 0, 0, 0, '0, 3'd0, "R6 broadcast");
    peek_gpr(2, "R6 dst2"); peek_gpr(3, "R6 dst3"); peek_gpr(1, "R6 untouched");

    // R10: R1 + R2 -> R3 in three steps
    load(1, 16'h7FFF, "R10 a"); load(2, 16'h0003, "R10 b");
    step(4'b0010, '0, 0, 1, 0, 0, 0, '0, 3'd0, "R10 s1");
    step(4'b0100, '0, 0, 0, 0, 1, 0, '0, 3'd0, "R10 s2");
    step('0, 4'b1000, 0, 0, 1, 0, 0, '0, 3'd0, "R10 s3");
    peek_gpr(3, "R10 result");

    // R8: each function code, A=tmp B=ext
    for (int f = 0; f < 8; f++) begin
      step('0, '0, 0, 1, 0, 0, 1, 16'h00F5, 3'd0, "R8 setA");
      step('0, '0, 0, 0, 0, 1, 1, 16'h0F3C, 3'(f), "R8 fn");
      step('0, '0, 0, 0, 1, 0, 0, '0, 3'd0, "R8 read");
    end
    // R8: subtraction wraps
    step('0, '0, 0, 1, 0, 0, 1, 16'h0001, 3'd0, "R8 wrapA");
    step('0, '0, 0, 0, 0, 1, 1, 16'h0002, 3'd1, "R8 wrap sub");
    step('0, '0, 0, 0, 1, 0, 0, '0, 3'd0, "R8 wrap read");

    // R7: result holds when its gate is clear even with bus activity
    step('0, 4'b0001, 0, 0, 0, 0, 1, 16'hAAAA, 3'd0, "R7 no capture");
    step('0, '0, 0, 0, 1, 0, 0, '0, 3'd0, "R7 res held");

    // R9: same-cycle read and write
    step(4'b0001, 4'b0001, 0, 0, 0, 0, 0, '0, 3'd0, "R9 self copy");
    peek_gpr(0, "R9 self kept");
    step('0, '0, 0, 1, 0, 0, 1, 16'h0010, 3'd0, "R9 setA");
    step('0, '0, 0, 0, 1, 1, 0, '0, 3'd0, "R9 res feedback");
    step('0, '0, 0, 0, 1, 0, 0, '0, 3'd0, "R9 res read");
    step('0, '0, 0, 1, 0, 1, 1, 16'h0100, 3'd0, "R9 tmp+res");
    step('0, '0, 0, 0, 1, 0, 0, '0, 3'd0, "R9 old tmp used");
    step('0, '0, 1, 0, 0, 0, 0, '0, 3'd0, "R9 tmp new");

    // R4/R5: illegal words flagged and nothing commits
    step(4'b0011, 4'b1100, 0, 1, 0, 1, 0, '0, 3'd0, "R4 two gpr");
    step('0, 4'b1111, 1, 1, 1, 1, 1, 16'h5A5A, 3'd2, "R4 many");
    step(4'b1000, 4'b0001, 0, 0, 0, 0, 1, 16'hC003, 3'd0, "R5 gpr+ext");
    for (int k = 0; k < N; k++) peek_gpr(k, "R5 gpr kept");
    step('0, '0, 1, 0, 0, 0, 0, '0, 3'd0, "R5 tmp kept");
    step('0, '0, 0, 0, 1, 0, 0, '0, 3'd0, "R5 res kept");

    // mixed random stream, mostly legal words
    for (int i = 0; i < 400; i++) begin
      logic [N+2:0] drv;
      int sel;
      sel = $urandom_range(0, N + 3);
      drv = (sel <= N + 2) ? ((N+3)'(1) << sel) : '0;
      if ($urandom_range(0, 9) == 0) drv |= (N+3)'($urandom);
      step(drv[N-1:0], N'($urandom), drv[N], 1'($urandom), drv[N+1], 1'($urandom),
           drv[N+2], W'($urandom), 3'($urandom), "R6 R7 R8 R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule